// File: doc/BRIEF.md
# Packet Ring Buffer Writer

This block takes fixed-length transport packets and stores each one as a 192-byte record in a circular region of memory. Each channel has its own region. A record is a 4-byte header followed by the 188 packet bytes. Packets arrive as 32-bit words, 47 words per packet, and the first word is flagged as start of packet. Each payload word is written to memory in the cycle it arrives. The header word goes to the start of the record in the cycle after the last payload word. The write pointer moves forward only when the header has been written, so a consumer never sees a partial record.

Each channel has four address registers (base, inclusive top, write pointer, read pointer), an enable bit, an overflow counter and a record sequence counter. All of them are reached through a single register port. A consumer reads the write pointer, drains records, and then writes the read pointer back. The block keeps one free record between the write and read pointers: a packet that would close that gap is dropped and counted.

A shared idle-request register lets software quiesce channels. It writes a channel mask together with a request flag. Each requested channel reports done once it has no record in flight. The OR of the done bits forms an interrupt line. Writing zero to the request register withdraws the request and clears every acknowledge.

Top module: `pkt_ring_writer`

## Requirements
- R1: An accepted packet at write pointer W produces its payload words at W+4, W+8, … W+188, one in each cycle its word arrives. In the following cycle it produces the header word at W. The header holds the channel index in bits [7:0], the channel's sequence count in [15:8], its overflow count in [23:16] and the constant 0xBC in [31:24].
- R2: The write pointer advances by 192 exactly once per record, on the clock edge that writes the header, and at no other time except a register write.
- R3: When W+192 exceeds the inclusive top address, the next write pointer is base. Every memory write falls within the channel's [base, top] range.
- R4: A packet is dropped, with no memory write, when its channel is enabled and the next write pointer equals the read pointer. The drop increments that channel's 8-bit overflow counter, and ch_full is high while this condition holds.
- R5: The enable bit is sampled at the start-of-packet word. A start seen with enable 0 causes no write and no counter change. Clearing enable during a record lets that record finish.
- R6: Register port select codes are 0 base, 1 top, 2 write pointer, 3 read pointer, 4 enable (bit 0), 5 overflow count, 6 idle request, 7 sequence count. A write takes effect on the next edge, and reg_rdata shows the selected register combinationally.
- R7: ch_occ for a channel equals (write pointer − read pointer) modulo the region size, in bytes.
- R8: Writing code 6 with bit 31 set and a channel mask in the low bits raises idle_done for each masked channel once it has no record in progress. The done bit stays low while a record is being written, and idle_irq is the OR of the done bits.
- R9: Writing zero to the idle-request register clears all idle_done bits and idle_irq on that edge.
- R10: A channel's sequence counter increments by one for each record it commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet word valid |
| in_sop | input | 1 | First word of a packet |
| in_chan | input | CW | Channel of the packet |
| in_data | input | 32 | Packet word |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | CW | Channel addressed by the register port |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| ch_full | output | NCH | Per-channel ring full |
| ch_occ | output | 32*NCH | Per-channel occupancy in bytes |
| idle_done | output | NCH | Per-channel idle acknowledge |
| idle_irq | output | 1 | OR of idle acknowledges |

## Verification
The bench fills a ring until one record slot is left. It expects the eighth packet to be dropped and counted. A design that allowed the pointers to meet would instead overwrite unread data with a write the scoreboard does not expect. After the read pointer is moved, the bench sends packets across the inclusive top boundary. This catches an off-by-one wrap, which would write past top or return to base one record early. It raises an idle request in the middle of a record and checks that the acknowledge stays low until the header has been written; an early acknowledge would let software reset pointers under a live write. It also clears enable mid-record and checks that the record still completes, which exposes a design that abandons a half-written record.

// File: rtl/prw_pkg.sv
package prw_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int PKT_BYTES  = 188;
  localparam int HDR_BYTES  = 4;
  localparam int XFER_ALIGN = 8;
  localparam int REC_BYTES  = ((PKT_BYTES + HDR_BYTES + XFER_ALIGN - 1) / XFER_ALIGN) * XFER_ALIGN;
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int PAY_WORDS  = PKT_BYTES / BEAT_BYTES;
  localparam int CNT_W      = $clog2(PAY_WORDS + 1);

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    SEL_BASE = 3'd0,
    SEL_TOP  = 3'd1,
    SEL_WP   = 3'd2,
    SEL_RP   = 3'd3,
    SEL_EN   = 3'd4,
    SEL_OVF  = 3'd5,
    SEL_IDLE = 3'd6,
    SEL_SEQ  = 3'd7
  } sel_e;

  // Pointer after one more record; top is inclusive.
  function automatic addr_t ring_next(addr_t wp, addr_t base, addr_t top);
    addr_t s;
    s = wp + addr_t'(REC_BYTES);
    if (s > top || s < wp) return base;
    return s;
  endfunction

  // Bytes held between read and write pointer.
  function automatic addr_t ring_occ(addr_t wp, addr_t rp, addr_t base, addr_t top);
    addr_t size;
    size = top - base + addr_t'(1);
    if (wp >= rp) return wp - rp;
    return wp + size - rp;
  endfunction

  function automatic logic [DATA_W-1:0] hdr_word(logic [7:0] chan, logic [7:0] seq,
                                                 logic [7:0] ovf);
    return {8'(PKT_BYTES), ovf, seq, chan};
  endfunction
endpackage

// File: rtl/prw_chan.sv
module prw_chan
  import prw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              ovf_inc,
  output addr_t             base_q,
  output addr_t             top_q,
  output addr_t             wp_q,
  output addr_t             rp_q,
  output logic              en_q,
  output logic [7:0]        ovf_q,
  output logic [7:0]        seq_q,
  output logic              full,
  output addr_t             occ
);
  addr_t wp_nxt;

  assign wp_nxt = ring_next(wp_q, base_q, top_q);
  assign full   = (wp_nxt == rp_q);
  assign occ    = ring_occ(wp_q, rp_q, base_q, top_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      top_q  <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      en_q   <= 1'b0;
      ovf_q  <= '0;
      seq_q  <= '0;
    end else begin
      if (commit) begin
        wp_q  <= wp_nxt;
        seq_q <= seq_q + 8'd1;
      end
      if (ovf_inc) ovf_q <= ovf_q + 8'd1;
      if (wr_en) begin
        case (wr_sel)
          SEL_BASE: base_q <= addr_t'(wr_data);
          SEL_TOP:  top_q  <= addr_t'(wr_data);
          SEL_WP:   wp_q   <= addr_t'(wr_data);
          SEL_RP:   rp_q   <= addr_t'(wr_data);
          SEL_EN:   en_q   <= wr_data[0];
          SEL_OVF:  ovf_q  <= wr_data[7:0];
          SEL_SEQ:  seq_q  <= wr_data[7:0];
          default:  ;
        endcase
      end
    end
  end

  AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_en && (wr_sel == SEL_WP || wr_sel == SEL_BASE)))
      |=> (wp_q == base_q || wp_q == $past(wp_q) + addr_t'(REC_BYTES)))
    else $error("wp step"); // R2
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !(wr_en && wr_sel == SEL_WP)) |=> $stable(wp_q))
    else $error("wp hold"); // R2
  AST_OVF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_inc && !(wr_en && wr_sel == SEL_OVF)) |=> ovf_q == $past(ovf_q) + 8'd1)
    else $error("ovf count"); // R4
  AST_SEQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(wr_en && wr_sel == SEL_SEQ)) |=> seq_q == $past(seq_q) + 8'd1)
    else $error("seq count"); // R10
endmodule

// File: rtl/prw_engine.sv
module prw_engine
  import prw_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [CW-1:0]     in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    ch_full,
  input  addr_t             ch_wp  [NCH],
  input  logic [7:0]        ch_seq [NCH],
  input  logic [7:0]        ch_ovf [NCH],
  output logic              mem_we,
  output addr_t             mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [CW-1:0]     wr_chan,
  output logic [NCH-1:0]    commit,
  output logic [NCH-1:0]    ovf_inc,
  output logic [NCH-1:0]    busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_HDR} st_e;

  st_e              st_q;
  logic [CW-1:0]    cur_q;
  addr_t            rec_q;
  logic [CNT_W-1:0] cnt_q;

  logic chan_ok, start, accept, drop_full, last_word;

  assign chan_ok   = (32'(in_chan) < NCH);
  assign start     = (st_q == ST_IDLE) && in_valid && in_sop && chan_ok;
  assign accept    = start && ch_en[in_chan] && !ch_full[in_chan];
  assign drop_full = start && ch_en[in_chan] && ch_full[in_chan];
  assign last_word = (st_q == ST_DATA) && in_valid && (cnt_q == CNT_W'(PAY_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      rec_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_DATA;
          cur_q <= in_chan;
          rec_q <= ch_wp[in_chan];
          cnt_q <= CNT_W'(1);
        end
        ST_DATA: if (in_valid) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_word) st_q <= ST_HDR;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = rec_q;
    mem_wdata = in_data;
    wr_chan   = cur_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        mem_we   = 1'b1;
        mem_addr = ch_wp[in_chan] + addr_t'(HDR_BYTES);
        wr_chan  = in_chan;
      end
      ST_DATA: if (in_valid) begin
        mem_we   = 1'b1;
        mem_addr = rec_q + addr_t'(HDR_BYTES) + addr_t'(cnt_q) * addr_t'(BEAT_BYTES);
      end
      default: begin
        mem_we    = 1'b1;
        mem_wdata = hdr_word(8'(cur_q), ch_seq[cur_q], ch_ovf[cur_q]);
      end
    endcase
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      commit[c]  = (st_q == ST_HDR) && (cur_q == CW'(c));
      ovf_inc[c] = drop_full && (in_chan == CW'(c));
      busy[c]    = (st_q != ST_IDLE) && (cur_q == CW'(c));
    end
  end

  AST_SOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |-> st_q == ST_IDLE)
    else $error("sop inside record"); // R1
  AST_HDR_AFTER_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> $past(st_q == ST_DATA && in_valid))
    else $error("header order"); // R1
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit))
    else $error("multiple commits"); // R2
  AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st_q == ST_IDLE) |-> ch_en[wr_chan])
    else $error("write on disabled channel"); // R5
endmodule

// File: rtl/prw_idle.sv
module prw_idle
  import prw_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    busy,
  output logic              flag_q,
  output logic [NCH-1:0]    mask_q,
  output logic [NCH-1:0]    done_q,
  output logic              irq
);
  assign irq = |done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= '0;
      done_q <= '0;
    end else if (wr_en) begin
      flag_q <= wr_data[DATA_W-1];
      mask_q <= wr_data[NCH-1:0];
      done_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (flag_q && mask_q[c] && !busy[c]) done_q[c] <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q[c]) |-> $past(!busy[c]))
      else $error("idle ack while busy"); // R8
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == '0) |=> (done_q == '0 && !irq))
    else $error("idle clear"); // R9
endmodule

// File: rtl/pkt_ring_writer.sv
module pkt_ring_writer
  import prw_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic [CW-1:0]       in_chan,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                reg_we,
  input  logic [CW-1:0]       reg_chan,
  input  logic [2:0]          reg_sel,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [NCH-1:0]      ch_full,
  output logic [ADDR_W*NCH-1:0] ch_occ,
  output logic [NCH-1:0]      idle_done,
  output logic                idle_irq
);
  sel_e         sel;
  addr_t        base_a [NCH];
  addr_t        top_a  [NCH];
  addr_t        wp_a   [NCH];
  addr_t        rp_a   [NCH];
  logic [7:0]   ovf_a  [NCH];
  logic [7:0]   seq_a  [NCH];
  logic [NCH-1:0] en_v, commit, ovf_inc, busy;
  logic [CW-1:0]  wr_chan;
  logic           idle_flag;
  logic [NCH-1:0] idle_mask;

  assign sel = sel_e'(reg_sel);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    addr_t occ_c;
    prw_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_we && reg_chan == CW'(c) && sel != SEL_IDLE),
      .wr_sel (sel),
      .wr_data(reg_wdata),
      .commit (commit[c]),
      .ovf_inc(ovf_inc[c]),
      .base_q (base_a[c]),
      .top_q  (top_a[c]),
      .wp_q   (wp_a[c]),
      .rp_q   (rp_a[c]),
      .en_q   (en_v[c]),
      .ovf_q  (ovf_a[c]),
      .seq_q  (seq_a[c]),
      .full   (ch_full[c]),
      .occ    (occ_c)
    );
    assign ch_occ[c*ADDR_W +: ADDR_W] = occ_c;
  end

  prw_engine #(.NCH(NCH), .CW(CW)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_chan  (in_chan),
    .in_data  (in_data),
    .ch_en    (en_v),
    .ch_full  (ch_full),
    .ch_wp    (wp_a),
    .ch_seq   (seq_a),
    .ch_ovf   (ovf_a),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .wr_chan  (wr_chan),
    .commit   (commit),
    .ovf_inc  (ovf_inc),
    .busy     (busy)
  );

  prw_idle #(.NCH(NCH)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we && sel == SEL_IDLE),
    .wr_data(reg_wdata),
    .busy   (busy),
    .flag_q (idle_flag),
    .mask_q (idle_mask),
    .done_q (idle_done),
    .irq    (idle_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_BASE: reg_rdata = DATA_W'(base_a[reg_chan]);
      SEL_TOP:  reg_rdata = DATA_W'(top_a[reg_chan]);
      SEL_WP:   reg_rdata = DATA_W'(wp_a[reg_chan]);
      SEL_RP:   reg_rdata = DATA_W'(rp_a[reg_chan]);
      SEL_EN:   reg_rdata = DATA_W'(en_v[reg_chan]);
      SEL_OVF:  reg_rdata = DATA_W'(ovf_a[reg_chan]);
      SEL_SEQ:  reg_rdata = DATA_W'(seq_a[reg_chan]);
      default:  begin
        reg_rdata = DATA_W'(idle_mask);
        reg_rdata[DATA_W-1] = idle_flag;
      end
    endcase
  end

  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= base_a[wr_chan] && mem_addr <= top_a[wr_chan]))
    else $error("write outside ring"); // R3
endmodule

// File: tb/pkt_ring_writer_test.sv
module pkt_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [0:0]  in_chan = '0;
  logic [31:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [0:0]  reg_chan = '0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  ch_full, idle_done;
  logic [63:0] ch_occ;
  logic        idle_irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  logic [31:0] m_base[2], m_top[2], m_wp[2], m_rp[2];
  logic [7:0]  m_ovf[2], m_seq[2];
  bit          m_en[2];

  always #2 clk = ~clk;

  pkt_ring_writer uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every memory write must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk("R4/R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R1 address", mem_addr, e[63:32]);
        chk("R1 data", mem_wdata, e[31:0]);
      end
    end
  end

  function automatic logic [31:0] m_next(int ch);
    logic [31:0] off;
    off = m_wp[ch] - m_base[ch] + 32'd192;
    if (off >= m_top[ch] - m_base[ch] + 32'd1) return m_base[ch];
    return m_wp[ch] + 32'd192;
  endfunction

  task automatic reg_write(input int ch, input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_chan = 1'(ch); reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    case (sel)
      3'd0: m_base[ch] = d;
      3'd1: m_top[ch] = d;
      3'd2: m_wp[ch] = d;
      3'd3: m_rp[ch] = d;
      3'd4: m_en[ch] = d[0];
      3'd5: m_ovf[ch] = d[7:0];
      3'd7: m_seq[ch] = d[7:0];
      default: ;
    endcase
  endtask

  task automatic reg_read(input int ch, input logic [2:0] sel, output logic [31:0] d);
    @(posedge clk); #1;
    reg_chan = 1'(ch); reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic send_pkt(input int ch, input logic [7:0] tag);
    logic [31:0] r;
    if (m_en[ch]) begin
      if (m_next(ch) == m_rp[ch]) m_ovf[ch]++;
      else begin
        r = m_wp[ch];
        for (int k = 0; k < 47; k++)
          exp_q.push_back({r + 32'd4 + 32'(4 * k), tag, 8'(ch), 16'(k)});
        exp_q.push_back({r, 8'hBC, m_ovf[ch], m_seq[ch], 8'(ch)});
        m_seq[ch]++;
        m_wp[ch] = m_next(ch);
      end
    end
    for (int k = 0; k < 47; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sop = (k == 0); in_chan = 1'(ch);
      in_data = {tag, 8'(ch), 16'(k)};
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic cfg(input int ch, input logic [31:0] base);
    reg_write(ch, 3'd0, base);
    reg_write(ch, 3'd1, base + 32'd1535);
    reg_write(ch, 3'd2, base);
    reg_write(ch, 3'd3, base);
    reg_write(ch, 3'd4, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 2; c++) begin
      m_base[c] = 0; m_top[c] = 0; m_wp[c] = 0; m_rp[c] = 0;
      m_en[c] = 0; m_ovf[c] = 0; m_seq[c] = 0;
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset mem_we", 32'(mem_we), 0);
    chk("R9 reset irq", 32'(idle_irq), 0);
    reg_read(0, 3'd2, d); chk("R6 reset wp", d, 0);
    reg_read(0, 3'd4, d); chk("R5 reset enable", d, 0);

    // one record on channel 0
    cfg(0, 32'h1000);
    reg_read(0, 3'd1, d); chk("R6 top readback", d, 32'h15FF);
    send_pkt(0, 8'h11);
    reg_read(0, 3'd2, d); chk("R2 wp after one record", d, 32'h10C0);
    @(negedge clk); chk("R7 occupancy one record", ch_occ[31:0], 32'd192);

    // disabled channel 1: no writes, nothing changes
    send_pkt(1, 8'h22);
    reg_read(1, 3'd2, d); chk("R5 disabled wp", d, 0);
    reg_read(1, 3'd5, d); chk("R5 disabled ovf", d, 0);

    // fill ring: six more fit, the seventh is dropped
    for (int i = 0; i < 7; i++) send_pkt(0, 8'h30 + 8'(i));
    reg_read(0, 3'd2, d); chk("R4 wp at full", d, 32'h1540);
    @(negedge clk); chk("R4 full flag", 32'(ch_full[0]), 1);
    chk("R7 occupancy full", ch_occ[31:0], 32'd1344);
    reg_read(0, 3'd5, d); chk("R4 overflow count", d, 1);

    // free two records, then wrap at the inclusive top
    reg_write(0, 3'd3, 32'h1180);
    @(negedge clk); chk("R4 full released", 32'(ch_full[0]), 0);
    send_pkt(0, 8'h40);
    reg_read(0, 3'd2, d); chk("R3 wrap to base", d, 32'h1000);
    send_pkt(0, 8'h41);
    reg_read(0, 3'd2, d); chk("R3 wp after wrap", d, 32'h10C0);
    @(negedge clk); chk("R7 occupancy wrapped", ch_occ[31:0], 32'd1344);
    chk("R4 full after wrap", 32'(ch_full[0]), 1);
    reg_read(0, 3'd7, d); chk("R10 sequence count", d, 9);

    // idle request while channel 1 is mid-record
    cfg(1, 32'h2000);
    fork
      send_pkt(1, 8'h50);
      begin
        repeat (10) @(posedge clk);
        reg_write(1, 3'd6, 32'h8000_0002);
        for (int i = 0; i < 5; i++) begin
          @(negedge clk); chk("R8 done low while busy", 32'(idle_done), 0);
        end
      end
    join
    @(negedge clk);
    chk("R8 done after record", 32'(idle_done), 32'h2);
    chk("R8 irq raised", 32'(idle_irq), 1);
    reg_read(0, 3'd6, d); chk("R6 idle request readback", d, 32'h8000_0002);
    reg_write(0, 3'd6, 32'h0);
    @(negedge clk);
    chk("R9 done cleared", 32'(idle_done), 0);
    chk("R9 irq cleared", 32'(idle_irq), 0);

    // idle request on a quiet channel
    reg_write(0, 3'd6, 32'h8000_0001);
    @(posedge clk); @(negedge clk);
    chk("R8 quiet channel ack", 32'(idle_done), 32'h1);
    reg_write(0, 3'd6, 32'h0);
    @(negedge clk); chk("R9 clear again", 32'(idle_irq), 0);

    // enable cleared mid-record: record still completes
    fork
      send_pkt(1, 8'h60);
      begin
        repeat (10) @(posedge clk);
        reg_write(1, 3'd4, 32'd0);
      end
    join
    reg_read(1, 3'd2, d); chk("R5 record completes after disable", d, 32'h2180);
    send_pkt(1, 8'h61);
    reg_read(1, 3'd2, d); chk("R5 wp held when disabled", d, 32'h2180);
    reg_read(1, 3'd5, d); chk("R5 no overflow when disabled", d, 0);
    reg_read(1, 3'd7, d); chk("R10 channel 1 sequence", d, 2);

    repeat (4) @(posedge clk);
    chk("R1 all expected writes seen", 32'(exp_q.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule